// File: doc/BRIEF.md
# Stream-to-Memory Burst Write Scheduler

This block empties a first-word-fall-through input FIFO into a memory write engine that takes a command (start address plus byte count) on one handshake port and the matching data on an AXI4-Stream port. It watches the FIFO's exact word count. It batches a transfer once a full block of data has gathered, or once a timer in the waiting state runs out while fewer words are present. It then issues one command and streams exactly the declared number of beats.

The block keeps a write offset into a circular memory region of parameterised size. Each accepted command advances the offset by its byte count, wrapping at the region end, and the updated address is exported for a read-side consumer. The FIFO may keep filling while a transfer drains it. Words that arrive after the count is sampled are left for the next transfer.

Top module: `burst_write_sched`

## Requirements
- R1: While reset is held low at a clock edge, and right after it is released, `cmd_valid`, `m_tvalid` and `fifo_rd` are low and `wr_ptr` equals `BASE_ADDR`.
- R2: While `fifo_empty` is high and no transfer is pending, no command is issued and no beat is sent.
- R3: When data appears in an idle block and the FIFO already holds at least `THRESH_BYTES`, `cmd_valid` rises two clock edges after the data appears.
- R4: When the FIFO holds fewer than `THRESH_BYTES`, `cmd_valid` rises `TIMEOUT`+1 clock edges after the data appears in an idle block. `cmd_btt` is the sampled word count times `DATA_W`/8.
- R5: `cmd_btt` (23-bit byte count) is never zero and never exceeds `THRESH_BYTES`, even when the FIFO holds more. The excess goes into a later transfer.
- R6: `cmd_valid`, `cmd_addr` and `cmd_btt` stay stable until `cmd_ready` is seen, and no data beat is sent before the command is accepted.
- R7: Each transfer sends exactly `cmd_btt`/(`DATA_W`/8) beats, carrying FIFO words in order with none duplicated or dropped. Words pushed during a transfer belong to the next one.
- R8: `m_tlast` is high on the final beat of each transfer and on no other beat.
- R9: `fifo_rd` is high exactly on cycles where `m_tvalid` and `m_tready` are both high, so backpressure never pops a word.
- R10: `cmd_addr` is `BASE_ADDR` plus the current offset. On command acceptance the offset advances by `cmd_btt` modulo `REGION_BYTES`, and `wr_ptr` shows the new address from the next cycle.
- R11: The cycle after the final beat, `m_tvalid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_empty | input | 1 | Input FIFO holds no word |
| fifo_count | input | CNT_W | Exact number of words in the input FIFO |
| fifo_data | input | DATA_W | Head word of the input FIFO (first-word-fall-through) |
| fifo_rd | output | 1 | Pop the head word |
| cmd_valid | output | 1 | Write command offered |
| cmd_ready | input | 1 | Engine accepts the command |
| cmd_addr | output | ADDR_W | Start address of the transfer |
| cmd_btt | output | 23 | Bytes in the transfer |
| m_tdata | output | DATA_W | Stream data |
| m_tvalid | output | 1 | Stream beat valid |
| m_tready | input | 1 | Engine accepts the beat |
| m_tlast | output | 1 | Final beat of the transfer |
| wr_ptr | output | ADDR_W | Next write address in the region |

## Verification
The main function is driven with four fill patterns: a small partial batch that only the timer can release, a batch exactly at the threshold, one word short of it, and an overfull batch that must be split. Together they separate the threshold path from the timer path and expose any off-by-one in the comparison or the cap. The overfull case runs under periodic stream backpressure, with extra words pushed mid-transfer, which tells a correct sampled count apart from one that follows the live FIFO level. A delayed command acceptance, and a sequence whose running total crosses the region end, check command holding and pointer wrap.

// File: rtl/bws_pkg.sv
// Package: shared types and constants of the burst write scheduler.
// Assumes: nothing beyond IEEE 1800-2017.
package bws_pkg;
    localparam int BTT_W = 23;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_CMD  = 2'd2,
        ST_DATA = 2'd3
    } bws_state_e;
endpackage

// File: rtl/bws_timer.sv
// Module: wait timer for the filling state. Cleared whenever run is low,
// counts while run is high and flags the terminal cycle.
// Assumes: TIMEOUT >= 1.
module bws_timer #(
    parameter int TIMEOUT = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int TW = $clog2(TIMEOUT + 1);

    logic [TW-1:0] cnt_q;

    assign expired = run && (cnt_q == TW'(TIMEOUT - 1));

    // Counter: zero outside the filling state, advance inside it.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (!expired) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    a_r4_timer_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= TW'(TIMEOUT - 1));
endmodule

// File: rtl/bws_wrptr.sv
// Module: circular write offset. Advances by the accepted byte count and
// wraps modulo the region size; exports base plus offset.
// Assumes: each step is no larger than REGION_BYTES.
module bws_wrptr #(
    parameter int                ADDR_W       = 32,
    parameter int                BTT_W        = 23,
    parameter int                REGION_BYTES = 65536,
    parameter logic [ADDR_W-1:0] BASE_ADDR    = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic [BTT_W-1:0]  step,
    output logic [ADDR_W-1:0] ptr
);
    logic [ADDR_W-1:0] off_q;
    logic [ADDR_W:0]   sum;
    logic [ADDR_W:0]   wrapped;

    // Next offset: add the step, fold back once past the region end.
    always_comb begin
        sum     = {1'b0, off_q} + (ADDR_W + 1)'(step);
        wrapped = (sum >= (ADDR_W + 1)'(REGION_BYTES)) ? sum - (ADDR_W + 1)'(REGION_BYTES) : sum;
    end

    // Offset register: reset to the region start, update on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_q <= '0;
        end else if (adv) begin
            off_q <= wrapped[ADDR_W-1:0];
        end
    end

    assign ptr = BASE_ADDR + off_q;

    a_r10_in_region: assert property (@(posedge clk) disable iff (!rst_n)
        off_q < ADDR_W'(REGION_BYTES));
endmodule

// File: rtl/bws_beats.sv
// Module: remaining-beat counter. Loaded with the sampled transfer length,
// decremented on each stream handshake, flags the final beat.
// Assumes: no handshake arrives while the count is zero.
module bws_beats #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             fire,
    output logic [CNT_W-1:0] rem,
    output logic             last
);
    logic [CNT_W-1:0] rem_q;

    // Beat count: load at sampling, count down per accepted beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
        end else if (load) begin
            rem_q <= load_val;
        end else if (fire) begin
            rem_q <= rem_q - 1'b1;
        end
    end

    assign rem  = rem_q;
    assign last = (rem_q == CNT_W'(1));

    a_r7_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> rem_q != '0);
endmodule

// File: rtl/burst_write_sched.sv
// Module: stream-to-memory burst write scheduler (top). Waits for a full
// block or a timeout, issues one write command, then streams exactly the
// declared beats from a first-word-fall-through FIFO.
// Assumes: this block is the FIFO's only reader; DATA_W/8 is a power of two;
// THRESH_BYTES <= REGION_BYTES and THRESH_BYTES/(DATA_W/8) fits in CNT_W.
module burst_write_sched
    import bws_pkg::*;
#(
    parameter int                DATA_W       = 32,
    parameter int                CNT_W        = 12,
    parameter int                THRESH_BYTES = 4096,
    parameter int                TIMEOUT      = 256,
    parameter int                ADDR_W       = 32,
    parameter int                REGION_BYTES = 65536,
    parameter logic [ADDR_W-1:0] BASE_ADDR    = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_empty,
    input  logic [CNT_W-1:0]  fifo_count,
    input  logic [DATA_W-1:0] fifo_data,
    output logic              fifo_rd,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [BTT_W-1:0]  cmd_btt,
    output logic [DATA_W-1:0] m_tdata,
    output logic              m_tvalid,
    input  logic              m_tready,
    output logic              m_tlast,
    output logic [ADDR_W-1:0] wr_ptr
);
    localparam int BPB          = DATA_W / 8;
    localparam int THRESH_BEATS = THRESH_BYTES / BPB;

    bws_state_e       state_q, state_d;
    logic             timer_exp;
    logic             full_block;
    logic             load;
    logic [CNT_W-1:0] load_val;
    logic [CNT_W-1:0] rem;
    logic             last;
    logic             beat_fire;
    logic             cmd_fire;

    assign full_block = fifo_count >= CNT_W'(THRESH_BEATS);
    assign load_val   = full_block ? CNT_W'(THRESH_BEATS) : fifo_count;
    assign beat_fire  = m_tvalid && m_tready;
    assign cmd_fire   = cmd_valid && cmd_ready;

    // Next-state logic: idle, fill, command, data.
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        unique case (state_q)
            ST_IDLE: if (!fifo_empty) state_d = ST_FILL;
            ST_FILL: begin
                if (full_block || (timer_exp && fifo_count != '0)) begin
                    load    = 1'b1;
                    state_d = ST_CMD;
                end else if (timer_exp) begin
                    state_d = ST_IDLE;
                end
            end
            ST_CMD:  if (cmd_ready) state_d = ST_DATA;
            ST_DATA: if (beat_fire && last) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    bws_timer #(
        .TIMEOUT(TIMEOUT)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (state_q == ST_FILL),
        .expired(timer_exp)
    );

    bws_beats #(
        .CNT_W(CNT_W)
    ) u_beats (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .load_val(load_val),
        .fire    (beat_fire),
        .rem     (rem),
        .last    (last)
    );

    bws_wrptr #(
        .ADDR_W      (ADDR_W),
        .BTT_W       (BTT_W),
        .REGION_BYTES(REGION_BYTES),
        .BASE_ADDR   (BASE_ADDR)
    ) u_wrptr (
        .clk  (clk),
        .rst_n(rst_n),
        .adv  (cmd_fire),
        .step (cmd_btt),
        .ptr  (wr_ptr)
    );

    assign cmd_valid = (state_q == ST_CMD);
    assign cmd_addr  = wr_ptr;
    assign cmd_btt   = BTT_W'(32'(rem) * BPB);
    assign m_tvalid  = (state_q == ST_DATA);
    assign m_tdata   = fifo_data;
    assign m_tlast   = m_tvalid && last;
    assign fifo_rd   = beat_fire;

    a_r6_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr) && $stable(cmd_btt)));

    a_r6_data_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(m_tvalid) |-> $past(cmd_valid && cmd_ready));

    a_r5_btt_cap: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_btt != '0 && cmd_btt <= BTT_W'(THRESH_BYTES)));

    a_r11_idle_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && m_tready && m_tlast) |=> !m_tvalid);

    a_r9_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd |-> !fifo_empty);

    a_r3_full_goes_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FILL && full_block) |=> cmd_valid);
endmodule

// File: tb/burst_write_sched_bench.sv
// Bench: directed scenarios against a FIFO model and a stream/command sink.
module burst_write_sched_bench;
    localparam int          DW   = 32;
    localparam int          CW   = 12;
    localparam int          TO   = 64;
    localparam int          REG  = 10240;
    localparam int          BPB  = DW / 8;
    localparam logic [31:0] BASE = 32'h4000_0000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fifo_empty;
    logic [CW-1:0] fifo_count;
    logic [DW-1:0] fifo_data;
    logic          fifo_rd;
    logic          cmd_valid;
    logic          cmd_ready = 1'b0;
    logic [31:0]   cmd_addr;
    logic [22:0]   cmd_btt;
    logic [DW-1:0] m_tdata;
    logic          m_tvalid;
    logic          m_tready = 1'b1;
    logic          m_tlast;
    logic [31:0]   wr_ptr;

    always #2 clk = ~clk;

    burst_write_sched #(
        .DATA_W(DW), .CNT_W(CW), .THRESH_BYTES(4096), .TIMEOUT(TO),
        .ADDR_W(32), .REGION_BYTES(REG), .BASE_ADDR(BASE)
    ) u_burst_write_sched (
        .clk(clk), .rst_n(rst_n), .fifo_empty(fifo_empty), .fifo_count(fifo_count),
        .fifo_data(fifo_data), .fifo_rd(fifo_rd), .cmd_valid(cmd_valid),
        .cmd_ready(cmd_ready), .cmd_addr(cmd_addr), .cmd_btt(cmd_btt),
        .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tready(m_tready),
        .m_tlast(m_tlast), .wr_ptr(wr_ptr)
    );

    // FIFO model: each word's value is its push index.
    int wi = 0;
    int ri = 0;
    assign fifo_count = CW'(wi - ri);
    assign fifo_empty = (wi == ri);
    assign fifo_data  = DW'(ri);
    always @(posedge clk) if (fifo_rd) ri <= ri + 1;

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Stream backpressure driver.
    bit bp_mode = 1'b0;
    int phase = 0;
    always @(posedge clk) begin
        #1;
        m_tready = bp_mode ? (phase % 3 != 2) : 1'b1;
        phase++;
    end

    // Sink monitor: command fields, beat order, last flag, pop pairing.
    int exp_seq = 0, cur_beats = 0, beat_cnt = 0, model_off = 0, exp_btt = 0, done_cnt = 0;
    bit in_xfer = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (cmd_valid && cmd_ready) begin
                chk(cmd_addr == BASE + 32'(model_off), "R10", "cmd_addr", cmd_addr, BASE + 32'(model_off));
                chk(int'(cmd_btt) == exp_btt, "R7", "cmd_btt", cmd_btt, exp_btt);
                model_off = (model_off + int'(cmd_btt)) % REG;
                cur_beats = int'(cmd_btt) / BPB;
                beat_cnt  = 0;
                in_xfer   = 1'b1;
            end
            if (m_tvalid) chk(fifo_rd == m_tready, "R9", "fifo_rd vs tready", fifo_rd, m_tready);
            if (!m_tvalid) chk(!fifo_rd, "R9", "pop without beat", fifo_rd, 0);
            if (m_tvalid && m_tready) begin
                chk(in_xfer, "R6", "beat before command", 0, 1);
                chk(m_tdata == DW'(exp_seq), "R7", "beat data", m_tdata, exp_seq);
                exp_seq++;
                beat_cnt++;
                chk(m_tlast == (beat_cnt == cur_beats), "R8", "tlast", m_tlast, beat_cnt == cur_beats);
                if (beat_cnt == cur_beats) begin
                    in_xfer = 1'b0;
                    done_cnt++;
                end
            end
        end
    end

    task automatic push(input int n);
        @(posedge clk); #1;
        wi = wi + n;
    endtask

    // Returns clock edges from the push to the first cmd_valid.
    task automatic wait_cmd(output int lat);
        int k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (!cmd_valid && k < 5000);
        lat = k - 1;
    endtask

    task automatic accept_cmd(input int hold, input int btt);
        logic [31:0] a0;
        logic [22:0] b0;
        exp_btt = btt;
        a0 = cmd_addr;
        b0 = cmd_btt;
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            chk(cmd_valid && cmd_addr == a0 && cmd_btt == b0, "R6", "command held", cmd_valid, 1);
            chk(!m_tvalid, "R6", "no beat before accept", m_tvalid, 0);
        end
        @(posedge clk); #1 cmd_ready = 1'b1;
        @(posedge clk); #1 cmd_ready = 1'b0;
        @(negedge clk);
        chk(wr_ptr == BASE + 32'(model_off), "R10", "wr_ptr after accept", wr_ptr, BASE + 32'(model_off));
    endtask

    task automatic wait_done(input int target);
        int k = 0;
        while (done_cnt < target && k < 20000) begin
            @(negedge clk);
            k++;
        end
        chk(done_cnt >= target, "R7", "transfer completed", done_cnt, target);
        @(negedge clk);
        chk(!m_tvalid, "R11", "tvalid after last beat", m_tvalid, 0);
    endtask

    task automatic t_idle(input int cycles);
        bit seen = 1'b0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (cmd_valid || m_tvalid || fifo_rd) seen = 1'b1;
        end
        chk(!seen, "R2", "activity while empty", seen, 0);
    endtask

    task automatic t_timeout_small();
        int lat;
        push(10);
        wait_cmd(lat);
        chk(lat == TO + 1, "R4", "timeout latency", lat, TO + 1);
        chk(cmd_btt == 23'(40), "R4", "partial btt", cmd_btt, 40);
        accept_cmd(5, 40);
        wait_done(1);
    endtask

    task automatic t_overfull_backpressure();
        int lat;
        bp_mode = 1'b1;
        push(1500);
        wait_cmd(lat);
        chk(lat == 2, "R3", "threshold latency", lat, 2);
        chk(cmd_btt == 23'(4096), "R5", "capped btt", cmd_btt, 4096);
        accept_cmd(0, 4096);
        repeat (100) @(negedge clk);
        push(20);
        wait_done(2);
        wait_cmd(lat);
        chk(cmd_btt == 23'(496 * 4), "R7", "leftover plus late words", cmd_btt, 496 * 4);
        accept_cmd(0, 496 * 4);
        wait_done(3);
        bp_mode = 1'b0;
    endtask

    task automatic t_exact_threshold();
        int lat;
        push(1024);
        wait_cmd(lat);
        chk(lat == 2, "R3", "exact threshold latency", lat, 2);
        accept_cmd(1, 4096);
        wait_done(4);
    endtask

    task automatic t_one_short_wrap();
        int lat;
        push(1023);
        wait_cmd(lat);
        chk(lat == TO + 1, "R4", "one short latency", lat, TO + 1);
        chk(cmd_addr == BASE + 32'(10216), "R10", "addr before wrap", cmd_addr, BASE + 32'(10216));
        accept_cmd(0, 4092);
        chk(wr_ptr == BASE + 32'(4068), "R10", "wrapped wr_ptr", wr_ptr, BASE + 32'(4068));
        wait_done(5);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!cmd_valid && !m_tvalid && !fifo_rd, "R1", "outputs in reset", {cmd_valid, m_tvalid, fifo_rd}, 0);
        chk(wr_ptr == BASE, "R1", "wr_ptr in reset", wr_ptr, BASE);
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        chk(!cmd_valid && !m_tvalid && wr_ptr == BASE, "R1", "after release", wr_ptr, BASE);
        t_idle(100);
        t_timeout_small();
        t_overfull_backpressure();
        t_exact_threshold();
        t_one_short_wrap();
        t_idle(200);
        chk(exp_seq == wi, "R7", "all words streamed", exp_seq, wi);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule